// File: doc/BRIEF.md
# Bus-Attached Serial Port with Blocking Data Access

This block is a serial port that sits on a Wishbone bus as a slave with an 8-bit data path and four register addresses. Bytes written to the data address are queued in a transmit FIFO. They then leave on `txd_o` as frames of one start bit, eight data bits and one stop bit, with no parity. Frames that arrive on `rxd_i` are deserialised into a receive FIFO, and a read of the same data address takes bytes out of it.

A 16-bit divisor sets the bit rate. Its low and high bytes each have their own address. A timer makes a sub-bit tick every divisor+1 clock cycles, and one bit lasts 16 ticks. To get a rate from a clock frequency, the divisor is round(f_clk / (16 * rate)) - 1. For example, 50 MHz at 9600 baud gives 0x0145.

Flow control is done on the bus itself. A data access that cannot complete does not fail; the block simply holds back the acknowledge until the access can complete. The other addresses are always acknowledged at once. Software can therefore poll the status byte, or just issue a blocking access.

Top module: `uart_wb_port`

## Requirements
- R1: After reset, the status byte reads 0x00, both divisor bytes read 0x00, and `txd_o` is high.
- R2: A write to address 0 sends that byte on `txd_o` as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Bytes go out in the order they were written.
- R3: Address 2 holds the divisor low byte and address 3 holds the high byte, and both read back what was written. One serial bit lasts 16*(divisor+1) clock cycles. A start bit may be shortened by up to divisor+1 cycles, because a write to either byte restarts the tick phase.
- R4: The status byte at address 1 has these bits: bit 0 is RX FIFO full, bit 1 is RX at least half full, bit 2 is RX not empty, bit 4 is TX FIFO full, bit 5 is TX at least half full. Bits 3, 6 and 7 read 0, and writes to address 1 have no effect.
- R5: A write to address 0 while the TX FIFO is full gets no acknowledge until a slot frees. The byte is then accepted.
- R6: A read of address 0 while the RX FIFO is empty gets no acknowledge until a byte arrives. That byte is then returned.
- R7: Acknowledge is a one-cycle pulse. It comes on the clock edge after cyc and stb are sampled high, when the access can complete. Accesses to addresses 1 to 3 always complete at once.
- R8: The receiver samples each data bit at mid-bit, least significant bit first. Received bytes are read back in arrival order.
- R9: A received frame whose stop bit is low is discarded, and the next valid frame is still received.
- R10: A low pulse on `rxd_i` that has gone high again by the eighth tick after the falling edge does not start a frame. A byte that completes while the RX FIFO is full is discarded.
- R11: Reading status and popping address 0 while bit 2 is set empties the RX FIFO. This yields exactly the bytes that were held.
- R12: The half-full bits are set when the occupancy is at least DEPTH/2. The full bits are set when it equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 2 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Acknowledge pulse |
| txd_o | output | 1 | Serial transmit line, idles high |
| rxd_i | input | 1 | Serial receive line, asynchronous |

## Verification
The assertions assume that the master holds cyc, stb, we and address steady from the request until it sees acknowledge, and drops the strobe in the cycle after it. The bench drives every access from one task that follows this rule and leaves an idle cycle between accesses. The assertions also assume that `rxd_i` is held high outside frames. The bench drives the receive line at the same divisor as the block, so each bit lasts a whole bit period, and the line returns high after every frame.

// File: rtl/uart_wb_pkg.sv
package uart_wb_pkg;
  typedef enum logic [1:0] {
    ADR_DATA    = 2'd0,
    ADR_STAT    = 2'd1,
    ADR_DIV_LO  = 2'd2,
    ADR_DIV_HI  = 2'd3
  } reg_adr_e;

  localparam int ST_RX_FULL = 0;
  localparam int ST_RX_HALF = 1;
  localparam int ST_RX_AVAIL = 2;
  localparam int ST_TX_FULL = 4;
  localparam int ST_TX_HALF = 5;

  localparam int SUB_TICKS = 16;
  localparam int FRAME_BITS = 10;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             half_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign half_o  = (cnt_q >= CW'(DEPTH / 2));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(wptr_q));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o && $stable(rptr_q));
  assert_count_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] limit_i,
  input  logic         clr_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // limit only changes together with clr, so the phase never runs past it
  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_wb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       txd_o
);
  logic       busy_q;
  logic [3:0] sub_q, bit_q;
  logic [FRAME_BITS-1:0] sh_q;

  assign pop_o = !busy_q && valid_i;
  assign txd_o = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sub_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, data_i, 1'b0};
      sub_q  <= '0;
      bit_q  <= '0;
    end else if (busy_q && tick_i) begin
      sub_q <= sub_q + 1'b1;
      if (sub_q == 4'(SUB_TICKS - 1)) begin
        sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
        bit_q <= bit_q + 1'b1;
        if (bit_q == 4'(FRAME_BITS - 1)) busy_q <= 1'b0;
      end
    end
  end

  assert_stop_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && bit_q == 4'(FRAME_BITS - 1) |-> txd_o);
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !txd_o);
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_wb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  output logic       push_o,
  output logic [7:0] data_o
);
  logic [1:0] sync_q;
  logic       prev_q, active_q, push_q;
  logic [3:0] sub_q, bit_q;
  logic [7:0] sh_q;
  logic       rx_s;

  assign rx_s   = sync_q[1];
  assign push_o = push_q;
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 2'b11;
      prev_q   <= 1'b1;
      active_q <= 1'b0;
      push_q   <= 1'b0;
      sub_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      prev_q <= rx_s;
      push_q <= 1'b0;
      if (!active_q) begin
        if (prev_q && !rx_s) begin
          active_q <= 1'b1;
          sub_q    <= '0;
          bit_q    <= '0;
        end
      end else if (tick_i) begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == 4'(SUB_TICKS / 2 - 1)) begin
          if (bit_q == 4'd0) begin
            if (rx_s) active_q <= 1'b0;   // false start
          end else if (bit_q == 4'(FRAME_BITS - 1)) begin
            active_q <= 1'b0;
            push_q   <= rx_s;             // drop on framing error
          end else begin
            sh_q <= {rx_s, sh_q[7:1]};
          end
        end
        if (sub_q == 4'(SUB_TICKS - 1)) bit_q <= bit_q + 1'b1;
      end
    end
  end

  assert_stop_checked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(rx_s));
  assert_push_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
endmodule

// File: rtl/uart_wb_port.sv
module uart_wb_port
  import uart_wb_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wb_cyc_i,
  input  logic       wb_stb_i,
  input  logic       wb_we_i,
  input  logic [1:0] wb_adr_i,
  input  logic [7:0] wb_dat_i,
  output logic [7:0] wb_dat_o,
  output logic       wb_ack_o,
  output logic       txd_o,
  input  logic       rxd_i
);
  localparam int HI_W = DIV_W - 8;

  logic [DIV_W-1:0] div_q;
  logic ack_q, req, ready, hit, div_wr;
  logic tick;
  logic tx_empty, tx_full, tx_half, tx_pop, tx_push;
  logic rx_empty, rx_full, rx_half, rx_pop, rx_push;
  logic [7:0] tx_head, rx_head, rx_byte, status;
  reg_adr_e adr;

  assign adr = reg_adr_e'(wb_adr_i);
  assign req = wb_cyc_i && wb_stb_i && !ack_q;

  always_comb begin
    ready = 1'b1;
    if (adr == ADR_DATA) ready = wb_we_i ? !tx_full : !rx_empty;
  end

  assign hit     = req && ready;
  assign tx_push = hit && wb_we_i && adr == ADR_DATA;
  assign rx_pop  = hit && !wb_we_i && adr == ADR_DATA;
  assign div_wr  = hit && wb_we_i && (adr == ADR_DIV_LO || adr == ADR_DIV_HI);

  always_comb begin
    status = '0;
    status[ST_RX_FULL]  = rx_full;
    status[ST_RX_HALF]  = rx_half;
    status[ST_RX_AVAIL] = !rx_empty;
    status[ST_TX_FULL]  = tx_full;
    status[ST_TX_HALF]  = tx_half;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      wb_dat_o <= '0;
      div_q    <= '0;
    end else begin
      ack_q <= hit;
      if (hit) begin
        unique case (adr)
          ADR_DATA:   if (!wb_we_i) wb_dat_o <= rx_head;
          ADR_STAT:   if (!wb_we_i) wb_dat_o <= status;
          ADR_DIV_LO: if (wb_we_i) div_q[7:0] <= wb_dat_i;
                      else wb_dat_o <= div_q[7:0];
          ADR_DIV_HI: if (wb_we_i) div_q[DIV_W-1:8] <= wb_dat_i[HI_W-1:0];
                      else wb_dat_o <= 8'(div_q[DIV_W-1:8]);
          default: ;
        endcase
      end
    end
  end

  assign wb_ack_o = ack_q;

  uart_tick_gen #(.W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .limit_i(div_q), .clr_i(div_wr), .tick_o(tick)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tx_push), .data_i(wb_dat_i),
    .pop_i(tx_pop), .data_o(tx_head), .empty_o(tx_empty), .full_o(tx_full), .half_o(tx_half)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_push), .data_i(rx_byte),
    .pop_i(rx_pop), .data_o(rx_head), .empty_o(rx_empty), .full_o(rx_full), .half_o(rx_half)
  );

  uart_tx_ser u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .valid_i(!tx_empty),
    .data_i(tx_head), .pop_o(tx_pop), .txd_o(txd_o)
  );

  uart_rx_deser u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_i),
    .push_o(rx_push), .data_o(rx_byte)
  );

  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);
  assert_ctrl_immediate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cyc_i && wb_stb_i && !wb_ack_o && wb_adr_i != 2'd0 |=> wb_ack_o);
  assert_tx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o && $past(wb_we_i) && $past(wb_adr_i) == 2'd0 |-> !$past(tx_full));
  assert_rx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o && !$past(wb_we_i) && $past(wb_adr_i) == 2'd0 |-> !$past(rx_empty));
endmodule

// File: tb/uart_wb_port_test.sv
module uart_wb_port_test;
  localparam int DEPTH = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wb_cyc_i = 1'b0, wb_stb_i = 1'b0, wb_we_i = 1'b0;
  logic [1:0] wb_adr_i = '0;
  logic [7:0] wb_dat_i = '0;
  logic [7:0] wb_dat_o;
  logic wb_ack_o, txd_o;
  logic rxd_i = 1'b1;

  int tests = 0, fails = 0;
  int bit_p = 16;
  logic [7:0] tx_seen [64];
  int tx_seen_n = 0;

  always #5 clk_i = ~clk_i;

  uart_wb_port #(.FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
    .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
    .wb_ack_o(wb_ack_o), .txd_o(txd_o), .rxd_i(rxd_i)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit we, input logic [1:0] adr, input logic [7:0] wdat,
                     output logic [7:0] rdat, output int waited);
    @(negedge clk_i);
    wb_cyc_i = 1'b1; wb_stb_i = 1'b1; wb_we_i = we; wb_adr_i = adr; wb_dat_i = wdat;
    waited = 0;
    do begin
      @(negedge clk_i);
      waited++;
    end while (!wb_ack_o);
    rdat = wb_dat_o;
    wb_cyc_i = 1'b0; wb_stb_i = 1'b0; wb_we_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] adr, input logic [7:0] d);
    logic [7:0] r; int w;
    bus(1'b1, adr, d, r, w);
  endtask

  task automatic rd(input logic [1:0] adr, output logic [7:0] d);
    int w;
    bus(1'b0, adr, 8'h00, d, w);
  endtask

  task automatic set_div(input int lim);
    wr(2'd2, 8'(lim));
    wr(2'd3, 8'(lim >> 8));
    bit_p = 16 * (lim + 1);
  endtask

  task automatic send(input logic [7:0] b, input bit stop);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd_i = fr[i];
      repeat (bit_p) @(negedge clk_i);
    end
    rxd_i = 1'b1;
    repeat (bit_p) @(negedge clk_i);
  endtask

  function automatic logic [7:0] rx_stat(input int n);
    logic [7:0] s;
    s = '0;
    s[0] = (n == DEPTH);
    s[1] = (n >= DEPTH / 2);
    s[2] = (n > 0);
    return s;
  endfunction

  // serial monitor on txd_o
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk_i);
      if (rst_ni && !txd_o) begin
        repeat (bit_p / 2) @(negedge clk_i);
        if (!txd_o) begin
          for (int i = 0; i < 8; i++) begin
            repeat (bit_p) @(negedge clk_i);
            b[i] = txd_o;
          end
          repeat (bit_p) @(negedge clk_i);
          if (tx_seen_n < 64) tx_seen[tx_seen_n] = b;
          tx_seen_n++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, s;
    int w, n, pops;
    logic [7:0] pat [8];
    pat = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h3C, 8'hC3};

    repeat (3) @(negedge clk_i);
    check("R1 txd idle in reset", int'(txd_o), 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 reset state
    rd(2'd1, d); check("R1 status after reset", d, 8'h00);
    rd(2'd2, d); check("R1 div lo after reset", d, 8'h00);
    rd(2'd3, d); check("R1 div hi after reset", d, 8'h00);
    check("R1 txd high", int'(txd_o), 1);

    // R7 immediate acknowledge on control addresses
    bus(1'b0, 2'd1, 8'h00, d, w); check("R7 status ack latency", w, 1);
    bus(1'b1, 2'd2, 8'h00, d, w); check("R7 div write ack latency", w, 1);
    bus(1'b1, 2'd1, 8'hFF, d, w); check("R7 status write ack latency", w, 1);
    rd(2'd1, d); check("R4 status write ignored", d, 8'h00);

    // R3 divisor readback
    wr(2'd2, 8'h45); wr(2'd3, 8'h01);
    rd(2'd2, d); check("R3 div lo readback", d, 8'h45);
    rd(2'd3, d); check("R3 div hi readback", d, 8'h01);
    set_div(0);
    repeat (4) @(negedge clk_i);

    // R2 transmit patterns at divisor 0
    tx_seen_n = 0;
    for (int i = 0; i < 8; i++) wr(2'd0, pat[i]);
    repeat (8 * 160 + 200) @(negedge clk_i);
    check("R2 frames sent", tx_seen_n, 8);
    for (int i = 0; i < 8; i++) check("R2 tx byte", tx_seen[i], pat[i]);

    // R4 R12 R10 receive fill with status sweep, then drop when full
    for (int i = 1; i <= DEPTH; i++) begin
      send(8'(i - 1), 1'b1);
      rd(2'd1, d); check("R12 rx status by occupancy", d, rx_stat(i));
    end
    send(8'hEE, 1'b1);
    rd(2'd1, d); check("R10 status still full", d, rx_stat(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd0, d); check("R8 rx order", d, i);
    end
    rd(2'd1, d); check("R10 overflow byte dropped", d, 8'h00);

    // R8 sweep remaining byte values
    for (int bt = 1; bt < 16; bt++) begin
      for (int i = 0; i < 16; i++) send(8'(bt * 16 + i), 1'b1);
      for (int i = 0; i < 16; i++) begin
        rd(2'd0, d); check("R8 rx value", d, bt * 16 + i);
      end
    end

    // R9 framing error
    send(8'h5A, 1'b0);
    rd(2'd1, d); check("R9 bad stop dropped", d, 8'h00);
    send(8'hA5, 1'b1);
    rd(2'd0, d); check("R9 recovery byte", d, 8'hA5);

    // R10 short start pulse
    @(negedge clk_i); rxd_i = 1'b0;
    repeat (3) @(negedge clk_i); rxd_i = 1'b1;
    repeat (200) @(negedge clk_i);
    rd(2'd1, d); check("R10 glitch ignored", d, 8'h00);

    // R6 blocking read
    fork
      bus(1'b0, 2'd0, 8'h00, d, w);
      begin repeat (60) @(negedge clk_i); send(8'h96, 1'b1); end
    join
    check("R6 read held off", int'(w > 60), 1);
    check("R6 read data", d, 8'h96);

    // R11 drain loop
    send(8'h11, 1'b1); send(8'h22, 1'b1); send(8'h33, 1'b1);
    pops = 0;
    rd(2'd1, s);
    while (s[2] && pops < 20) begin
      rd(2'd0, d); check("R11 drained byte", d, 8'h11 * (pops + 1));
      pops++;
      rd(2'd1, s);
    end
    check("R11 pops", pops, 3);
    check("R11 final status", s, 8'h00);

    // R3 start bit length at divisor 3
    set_div(3);
    repeat (10) @(negedge clk_i);
    tx_seen_n = 0;
    wr(2'd0, 8'h01);
    while (txd_o) @(negedge clk_i);
    n = 0;
    while (!txd_o) begin @(negedge clk_i); n++; end
    check("R3 start bit length", int'(n >= bit_p - 4 && n <= bit_p + 1), 1);
    repeat (12 * bit_p) @(negedge clk_i);
    check("R3 frame at divisor 3", tx_seen[0], 8'h01);

    // R5 fill TX and block
    tx_seen_n = 0;
    for (int k = 1; k <= DEPTH + 1; k++) begin
      wr(2'd0, 8'(k + 8'h40));
      repeat (2) @(negedge clk_i);
      rd(2'd1, d);
      n = k - 1;
      check("R4 tx status bits", d, ((n == DEPTH) ? 8'h10 : 8'h00) | ((n >= DEPTH / 2) ? 8'h20 : 8'h00));
    end
    bus(1'b1, 2'd0, 8'h7E, d, w);
    check("R5 write held off", int'(w >= 100), 1);
    repeat ((DEPTH + 3) * 10 * bit_p) @(negedge clk_i);
    check("R5 frames after block", tx_seen_n, DEPTH + 2);
    for (int k = 0; k < DEPTH + 1; k++) check("R5 tx byte order", tx_seen[k], k + 1 + 8'h40);
    check("R5 blocked byte sent", tx_seen[DEPTH + 1], 8'h7E);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule